// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block receives stereo audio on three wires: a bit clock, a frame clock that marks which channel is on the line, and a serial data line. One shift engine handles all four framing conventions. Right-justified framing places the word at the end of each half-frame. Left-justified framing starts the word at the frame-clock change. I2S-style framing starts it one bit clock later with the channel polarity inverted. DSP framing starts each word after a short high pulse on the frame clock and samples on the falling bit-clock edge. Words arrive twos-complement and MSB first, and in every format the left word comes before the right word.

The active format is the bitwise OR of a pin-driven select and a register-driven select. Either source can therefore control the block while the other is held at zero. After a word has been captured, it is delivered MSB-aligned on a 24-bit output for its channel, together with a one-cycle valid strobe in the bit-clock domain. The stream has no back-pressure. Each word is offered exactly once, and the consumer must take it in the strobe cycle. The data output keeps its value until the next word of the same channel replaces it, so a late reader can still fetch it from the held value.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is low, and until the first delivery after reset, both data outputs are zero and both valid strobes are low.
- R2: The effective format is fmt_pin OR fmt_reg, bit by bit, with this encoding: 00 right-justified, 01 I2S-style, 10 left-justified, 11 DSP.
- R3: In left-justified format, both lines are sampled on the rising bit-clock edge, and frame clock high marks the left channel. The bit sampled on the first rising edge that sees a changed frame clock is the MSB.
- R4: In I2S-style format, both lines are sampled on the rising edge, and frame clock low marks the left channel. The MSB is the bit one bit clock after the first edge that sees the change.
- R5: In DSP format, both lines are sampled on the falling edge. A falling edge that sees the frame clock go from low to high starts a word, and the MSB is sampled on the next falling edge. The first word after reset is left, and later words alternate right, left, and so on.
- R6: In right-justified format, wlen_sel sets the word length: 00 gives 24 bits, 01 gives 20 bits, 10 and 11 give 16 bits. Bit positions are zero-based, and the first rising edge that sees the frame-clock change is position 0. Capture starts at position 8, 12 or 16 respectively (32 minus the length) and takes exactly that many bits, however long the half-frame is.
- R7: A word shorter than 24 bits appears MSB-aligned with zeros below it. In formats other than right-justified, bits after the 24th are dropped.
- R8: A word is delivered on the bit-clock edge that samples the boundary starting the next word. The data and the valid strobe register on that edge. A valid strobe lasts one cycle, the two channels never strobe together, and data is held between strobes.
- R9: A boundary sampled while no word is in progress (the first boundary after reset) delivers nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Frame clock (channel level or DSP start pulse) |
| sdata | input | 1 | Serial data, MSB first |
| fmt_pin | input | 2 | Format select from pins |
| fmt_reg | input | 2 | Format select from a control register, zero after reset |
| wlen_sel | input | 2 | Word length for right-justified format |
| left_data | output | 24 | Last left word, MSB-aligned |
| left_valid | output | 1 | One-cycle strobe for a new left word |
| right_data | output | 24 | Last right word, MSB-aligned |
| right_valid | output | 1 | One-cycle strobe for a new right word |

## Verification
Two functions share a single edge: delivering the word that has just ended, and capturing the MSB of the next word. In left-justified format both happen on the same bit clock. This is provoked with left-justified traffic in which every word has its MSB set, including back-to-back 24-bit half-frames with no idle bits. The test is passed only if both the delivered word and the following word come out intact. Strobe counts per channel are compared with the number of boundaries sent, so a lost word or an extra strobe is caught at the same point.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } aud_fmt_e;

  // Number of bits a right-justified word carries for a given length select.
  function automatic int unsigned rj_word_len(logic [1:0] sel, int unsigned full_w);
    case (sel)
      2'b00:   return full_w;
      2'b01:   return full_w - 4;
      default: return full_w - 8;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_front.sv
// Line sampling and word-boundary detection. DSP framing samples both lines
// on the falling bit-clock edge; the rising-edge engine then sees those values.
module aud_rx_front
  import aud_rx_pkg::*;
(
  input  logic     bclk,
  input  logic     rst_n,
  input  logic     lrclk,
  input  logic     sdata,
  input  aud_fmt_e fmt,
  output logic     bit_o,
  output logic     start_o,
  output logic     lvl_left_o
);

  logic lr_fall_q;
  logic sd_fall_q;
  logic lr_prev_q;
  logic lr_s;
  logic use_fall;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_fall_q <= 1'b0;
      sd_fall_q <= 1'b0;
    end else begin
      lr_fall_q <= lrclk;
      sd_fall_q <= sdata;
    end
  end

  assign use_fall = (fmt == FMT_DSP);
  assign lr_s     = use_fall ? lr_fall_q : lrclk;
  assign bit_o    = use_fall ? sd_fall_q : sdata;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q <= 1'b0;
    end else begin
      lr_prev_q <= lr_s;
    end
  end

  // Level formats start a word on any frame-clock change; DSP on a rising pulse.
  assign start_o    = use_fall ? (lr_s & ~lr_prev_q) : (lr_s ^ lr_prev_q);
  assign lvl_left_o = (fmt == FMT_I2S) ? ~lr_s : lr_s;

endmodule

// File: rtl/aud_rx_window.sv
// Decides, per bit position within the current word slot, whether the bit
// belongs to the word and how many bits the word may hold.
module aud_rx_window
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int HALF_FRAME = 32,
  parameter int POS_W      = 7,
  parameter int NB_W       = 5
) (
  input  aud_fmt_e          fmt,
  input  logic [1:0]        wlen_sel,
  input  logic [POS_W-1:0]  pos,
  output logic              in_win,
  output logic [NB_W-1:0]   limit
);

  localparam int LEN_LONG  = rj_word_len(2'b00, SAMPLE_W);
  localparam int LEN_MID   = rj_word_len(2'b01, SAMPLE_W);
  localparam int LEN_SHORT = rj_word_len(2'b10, SAMPLE_W);

  localparam logic [POS_W-1:0] OFF_LONG  = POS_W'(HALF_FRAME - LEN_LONG);
  localparam logic [POS_W-1:0] OFF_MID   = POS_W'(HALF_FRAME - LEN_MID);
  localparam logic [POS_W-1:0] OFF_SHORT = POS_W'(HALF_FRAME - LEN_SHORT);
  localparam logic [POS_W-1:0] OFF_ZERO  = '0;
  localparam logic [POS_W-1:0] OFF_ONE   = POS_W'(1);

  localparam logic [NB_W-1:0] LIM_FULL  = NB_W'(SAMPLE_W);
  localparam logic [NB_W-1:0] LIM_MID   = NB_W'(LEN_MID);
  localparam logic [NB_W-1:0] LIM_SHORT = NB_W'(LEN_SHORT);

  logic [POS_W-1:0] first_pos;

  always_comb begin
    first_pos = OFF_ZERO;
    limit     = LIM_FULL;
    unique case (fmt)
      FMT_LJ:  first_pos = OFF_ZERO;
      FMT_I2S: first_pos = OFF_ONE;
      FMT_DSP: first_pos = OFF_ONE;
      FMT_RJ: begin
        case (wlen_sel)
          2'b00: begin
            first_pos = OFF_LONG;
            limit     = LIM_FULL;
          end
          2'b01: begin
            first_pos = OFF_MID;
            limit     = LIM_MID;
          end
          default: begin
            first_pos = OFF_SHORT;
            limit     = LIM_SHORT;
          end
        endcase
      end
      default: first_pos = OFF_ZERO;
    endcase
  end

  assign in_win = (pos >= first_pos);

endmodule

// File: rtl/aud_rx_engine.sv
// Shared shift engine: tracks the bit position within the current word slot,
// places accepted bits MSB-first, and hands the finished word out at the
// next boundary.
module aud_rx_engine
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int HALF_FRAME = 32,
  parameter int POS_W      = 7
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  aud_fmt_e            fmt,
  input  logic [1:0]          wlen_sel,
  input  logic                bit_in,
  input  logic                start,
  input  logic                lvl_left,
  output logic                done,
  output logic                done_left,
  output logic [SAMPLE_W-1:0] done_word
);

  localparam int NB_W = $clog2(SAMPLE_W + 1);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0]    pos_q, pos_cur;
  logic [NB_W-1:0]     nb_q, nb_cur, nb_next;
  logic [SAMPLE_W-1:0] sh_q, sh_cur, sh_next;
  logic                active_q;
  logic                ch_q, ch_next;
  logic                in_win;
  logic [NB_W-1:0]     limit;
  logic                cap;

  aud_rx_window #(
    .SAMPLE_W  (SAMPLE_W),
    .HALF_FRAME(HALF_FRAME),
    .POS_W     (POS_W),
    .NB_W      (NB_W)
  ) u_window (
    .fmt     (fmt),
    .wlen_sel(wlen_sel),
    .pos     (pos_cur),
    .in_win  (in_win),
    .limit   (limit)
  );

  always_comb begin
    if (start) begin
      pos_cur = '0;
    end else if (pos_q == POS_MAX) begin
      pos_cur = POS_MAX;
    end else begin
      pos_cur = pos_q + 1'b1;
    end
    nb_cur  = start ? '0 : nb_q;
    sh_cur  = start ? '0 : sh_q;
    cap     = in_win && (nb_cur < limit);
    sh_next = sh_cur;
    nb_next = nb_cur;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (cap && (nb_cur == NB_W'(SAMPLE_W - 1 - i))) begin
        sh_next[i] = bit_in;
      end
    end
    if (cap) begin
      nb_next = nb_cur + 1'b1;
    end
  end

  always_comb begin
    ch_next = ch_q;
    if (start) begin
      if (fmt == FMT_DSP) begin
        ch_next = active_q ? ~ch_q : 1'b1;
      end else begin
        ch_next = lvl_left;
      end
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= POS_MAX;
      nb_q     <= '0;
      sh_q     <= '0;
      active_q <= 1'b0;
      ch_q     <= 1'b1;
    end else begin
      pos_q    <= pos_cur;
      nb_q     <= nb_next;
      sh_q     <= sh_next;
      active_q <= active_q | start;
      ch_q     <= ch_next;
    end
  end

  assign done      = start & active_q;
  assign done_left = ch_q;
  assign done_word = sh_q;

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int HALF_FRAME = 32,
  parameter int POS_W      = 7
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                lrclk,
  input  logic                sdata,
  input  logic [1:0]          fmt_pin,
  input  logic [1:0]          fmt_reg,
  input  logic [1:0]          wlen_sel,
  output logic [SAMPLE_W-1:0] left_data,
  output logic                left_valid,
  output logic [SAMPLE_W-1:0] right_data,
  output logic                right_valid
);

  localparam int N_CH = 2;

  aud_fmt_e            fmt_eff;
  logic                bit_s, start_s, lvl_left_s;
  logic                done_s, done_left_s;
  logic [SAMPLE_W-1:0] done_word_s;
  logic [SAMPLE_W-1:0] data_q [N_CH];
  logic                vld_q  [N_CH];

  assign fmt_eff = aud_fmt_e'(fmt_pin | fmt_reg);

  aud_rx_front u_front (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .lrclk     (lrclk),
    .sdata     (sdata),
    .fmt       (fmt_eff),
    .bit_o     (bit_s),
    .start_o   (start_s),
    .lvl_left_o(lvl_left_s)
  );

  aud_rx_engine #(
    .SAMPLE_W  (SAMPLE_W),
    .HALF_FRAME(HALF_FRAME),
    .POS_W     (POS_W)
  ) u_engine (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .fmt      (fmt_eff),
    .wlen_sel (wlen_sel),
    .bit_in   (bit_s),
    .start    (start_s),
    .lvl_left (lvl_left_s),
    .done     (done_s),
    .done_left(done_left_s),
    .done_word(done_word_s)
  );

  // Channel 0 is left, channel 1 is right.
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic IS_LEFT = (c == 0);
    logic hit;
    assign hit = done_s && (done_left_s == IS_LEFT);
    always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[c] <= '0;
        vld_q[c]  <= 1'b0;
      end else begin
        vld_q[c] <= hit;
        if (hit) begin
          data_q[c] <= done_word_s;
        end
      end
    end
  end

  assign left_data   = data_q[0];
  assign left_valid  = vld_q[0];
  assign right_data  = data_q[1];
  assign right_valid = vld_q[1];

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                bclk,
  input logic                rst_n,
  input logic [1:0]          fmt_pin,
  input logic [1:0]          fmt_reg,
  input logic [1:0]          wlen_sel,
  input logic [SAMPLE_W-1:0] left_data,
  input logic                left_valid,
  input logic [SAMPLE_W-1:0] right_data,
  input logic                right_valid
);

  logic rj_short;
  assign rj_short = ((fmt_pin | fmt_reg) == 2'b00) && wlen_sel[1];

  p_one_channel_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    !(left_valid && right_valid));

  p_left_pulse_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    left_valid |=> !left_valid);

  p_right_pulse_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    right_valid |=> !right_valid);

  p_left_hold_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    !left_valid |-> $stable(left_data));

  p_right_hold_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    !right_valid |-> $stable(right_data));

  p_short_tail_zero_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    (rj_short && left_valid) |-> (left_data[SAMPLE_W-17:0] == '0));

endmodule

bind aud_serial_rx aud_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .bclk       (bclk),
  .rst_n      (rst_n),
  .fmt_pin    (fmt_pin),
  .fmt_reg    (fmt_reg),
  .wlen_sel   (wlen_sel),
  .left_data  (left_data),
  .left_valid (left_valid),
  .right_data (right_data),
  .right_valid(right_valid)
);

// File: tb/test_aud_serial_rx.sv
`timescale 1ns/1ps
module test_aud_serial_rx;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  fmt_pin = 2'b00;
  logic [1:0]  fmt_reg = 2'b00;
  logic [1:0]  wlen_sel = 2'b00;
  logic [23:0] left_data, right_data;
  logic        left_valid, right_valid;

  int n_vec = 0;
  int n_bad = 0;
  int lcnt = 0;
  int rcnt = 0;
  logic [23:0] lval = '0;
  logic [23:0] rval = '0;
  bit finished = 0;

  always #2 bclk = ~bclk;

  aud_serial_rx i_aud_serial_rx (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .lrclk      (lrclk),
    .sdata      (sdata),
    .fmt_pin    (fmt_pin),
    .fmt_reg    (fmt_reg),
    .wlen_sel   (wlen_sel),
    .left_data  (left_data),
    .left_valid (left_valid),
    .right_data (right_data),
    .right_valid(right_valid)
  );

  // Output monitor, sampling half a period after the active edge.
  always @(negedge bclk) begin
    if (rst_n) begin
      if (left_valid) begin
        lcnt++;
        lval = left_data;
      end
      if (right_valid) begin
        rcnt++;
        rval = right_data;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp24(logic [31:0] w, int n);
    if (n <= 24) return (w << (24 - n)) & 32'h00FF_FFFF;
    return (w >> (n - 24)) & 32'h00FF_FFFF;
  endfunction

  task automatic drive(bit dsp, bit lr, bit sd);
    if (dsp) begin
      @(posedge bclk);
      #1;
    end else begin
      @(negedge bclk);
    end
    lrclk = lr;
    sdata = sd;
  endtask

  // f: 0 RJ, 1 I2S, 2 LJ, 3 DSP
  task automatic send_half(int f, bit is_left, logic [31:0] w, int n, int h);
    for (int p = 0; p < h; p++) begin
      bit lr;
      bit sd;
      int st;
      lr = (f == 1) ? !is_left : ((f == 3) ? (p == 0) : is_left);
      st = 32 - n;
      case (f)
        2: sd = (p < n) ? w[n-1-p] : 1'b0;
        1, 3: sd = (p == 0) ? 1'b1 : ((p - 1 < n) ? w[n-p] : 1'b0);
        default: sd = (p < st) ? 1'b1 : ((p < st + n) ? w[n-1-(p-st)] : 1'b1);
      endcase
      drive(f == 3, lr, sd);
    end
  endtask

  task automatic run_cfg(int ci, int k);
    int f, n, h;
    logic [1:0] pin, rg, wl;
    string tag;
    logic [31:0] msk, wl_word, wr_word;
    int l0, r0;
    h = 32; wl = 2'b00; pin = 2'b00; rg = 2'b00;
    case (ci)
      0:  begin f = 2; n = 24; pin = 2'b10;             tag = "R3"; end
      1:  begin f = 2; n = 16; rg = 2'b10;              tag = "R2 R3"; end
      2:  begin f = 2; n = 28; pin = 2'b10; rg = 2'b10; tag = "R3 R7"; end
      3:  begin f = 2; n = 24; h = 24; pin = 2'b10;     tag = "R3 R8"; end
      4:  begin f = 1; n = 24; pin = 2'b01;             tag = "R4"; end
      5:  begin f = 1; n = 20; rg = 2'b01;              tag = "R2 R4"; end
      6:  begin f = 1; n = 30; pin = 2'b01;             tag = "R4 R7"; end
      7:  begin f = 3; n = 24; pin = 2'b11;             tag = "R5"; end
      8:  begin f = 3; n = 16; pin = 2'b01; rg = 2'b10; tag = "R2 R5"; end
      9:  begin f = 3; n = 28; rg = 2'b11;              tag = "R5 R7"; end
      10: begin f = 0; n = 24; wl = 2'b00;              tag = "R6"; end
      11: begin f = 0; n = 20; wl = 2'b01;              tag = "R6"; end
      12: begin f = 0; n = 16; wl = 2'b10;              tag = "R6 R7"; end
      13: begin f = 0; n = 16; wl = 2'b11;              tag = "R6"; end
      default: begin f = 0; n = 24; h = 48;             tag = "R6 long"; end
    endcase
    msk = (32'h1 << n) - 1;
    case (k)
      0: wl_word = msk;
      1: wl_word = 32'h1 << (n - 1);
      2: wl_word = (32'h9E37_79B9 * (ci + 1)) & msk;
      default: wl_word = (32'h7F4A_7C15 ^ (ci * 32'h0101_0101)) & msk;
    endcase
    wr_word = (~wl_word ^ (k * 32'h0000_3333)) & msk;
    if (k == 1) wr_word = (32'h1 << (n - 1)) | 32'h1;

    @(negedge bclk);
    rst_n = 1'b0;
    lrclk = 1'b0;
    sdata = 1'b0;
    fmt_pin = pin;
    fmt_reg = rg;
    wlen_sel = wl;
    repeat (2) @(negedge bclk);
    rst_n = 1'b1;
    l0 = lcnt;
    r0 = rcnt;
    for (int fr = 0; fr < 3; fr++) begin
      send_half(f, 1'b1, wl_word, n, h);
      send_half(f, 1'b0, wr_word, n, h);
    end
    send_half(f, 1'b1, wl_word, n, h);
    repeat (2) @(negedge bclk);
    check({tag, " left word"}, {8'h0, lval}, exp24(wl_word, n));
    check({tag, " right word"}, {8'h0, rval}, exp24(wr_word, n));
    check("R8 R9 left strobe count", lcnt - l0, (f == 1) ? 2 : 3);
    check("R8 R9 right strobe count", rcnt - r0, 3);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge bclk);
    check("R1 left data in reset", {8'h0, left_data}, 32'h0);
    check("R1 right data in reset", {8'h0, right_data}, 32'h0);
    check("R1 left valid in reset", {31'h0, left_valid}, 32'h0);
    check("R1 right valid in reset", {31'h0, right_valid}, 32'h0);
    for (int ci = 0; ci < 15; ci++) begin
      for (int k = 0; k < 4; k++) begin
        run_cfg(ci, k);
      end
    end
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bclk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R8 actual=still running expected=finished");
      report();
      $finish;
    end
  end

endmodule